// File: doc/BRIEF.md
# ATAPI Packet Phase Controller

This block is the host-side sequencer for a packet command sent to an ATAPI device. A command is launched with a start request that carries its direction and whether it uses DMA. On every device interrupt, the block samples the device status byte and the interrupt-reason byte. From these it builds a 3-bit phase event code and looks up an action and a next phase in a state-by-event table. Each action is reported on a one-cycle strobe. The strobes tell the surrounding logic to push the CDB, move a block of data in or out, start or halt the DMA engine, or read the final status. Completion is a separate done pulse rather than a phase of its own.

The block also absorbs common device misbehaviour:
- An interrupt taken while the device still reports busy is dropped.
- A drive that reports reason code 0 in place of the status phase is treated as finished.
- A phase that loses DRQ between transfers raises one warning, and only once.
- A data phase that runs against the command's direction raises a direction warning instead of moving data.

Top module: `atapi_phase_ctrl`

## Requirements
- R1: The event code is {IO, CoD, DRQ}. IO is bit 1 and CoD is bit 0 of `irq_reason`. DRQ is bit 3 of `dev_status`, and BSY is bit 7, DF is bit 5 and ERR is bit 0 of `dev_status`. The `phase` output encodes idle=0, command=1, CDB=2, data-in=3, data-out=4, DMA=5.
- R2: A start request in idle, with no completion pending, moves `phase` to command and pulses `start_ack` one cycle later. In any other case the request pulses `start_busy` and leaves `phase` unchanged.
- R3: An interrupt taken while idle, or with BSY set, produces no strobe and leaves `phase` unchanged.
- R4: In the command phase, event 3 pulses `cdb_send` and moves to CDB. Event 6 completes the command. Any other event pulses `warn_unknown` and keeps the phase. At most one of the action strobes fires per interrupt.
- R5: In the CDB phase:
  - Event 1 moves to data-out with a transfer-out action.
  - Event 5 moves to data-in with a transfer-in action.
  - Events 2, 3 and 4 stay with no strobe.
  - Event 6 completes the command.
  - Event 7 pulses `warn_unknown`.
- R6: In data-in, event 5 transfers in. In data-out, event 1 transfers out. Events 2 and 4 keep the phase as an idle event, and event 6 completes. Any other nonzero event pulses `warn_unknown` and keeps the phase.
- R7: When the CDB is sent for a DMA command, `dma_go` pulses with `cdb_send` and the phase becomes DMA. In DMA, every event except 0 and 6 pulses `warn_unknown` and stays.
- R8: A completion outside DMA pulses `cmd_done` one cycle after the interrupt. A completion from DMA first pulses `dma_halt` one cycle after the interrupt, then `cmd_done` the next cycle. The phase returns to idle in both cases.
- R9: `cmd_err` accompanies `cmd_done` when DF or ERR was set in the completing status. `resid_clear` accompanies `cmd_done` only for a DMA completion whose `xfer_fault` was low.
- R10: Event 0 in the CDB, data or DMA phase completes the command like event 6. It pulses `warn_bad_reason` only on its first occurrence since reset.
- R11: An idle event (2 or 4) in data-in or data-out pulses `warn_bogus_drq` only on its first occurrence since reset.
- R12: A transfer-in event on a command not marked read, or a transfer-out event on one not marked write, pulses `warn_dir` instead of the data strobe. The phase still follows the table.
- R13: A synchronous active-high `rst` forces idle, clears all strobes and clears both once-only warning memories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to launch a packet command |
| start_rd | input | 1 | Command reads data from the device |
| start_wr | input | 1 | Command writes data to the device |
| start_dma | input | 1 | Command moves its data by DMA |
| start_ack | output | 1 | Start accepted |
| start_busy | output | 1 | Start refused |
| irq_valid | input | 1 | Device interrupt, status and reason valid |
| dev_status | input | 8 | Device status byte |
| irq_reason | input | 8 | Interrupt-reason byte |
| xfer_fault | input | 1 | DMA transport error, sampled with the interrupt |
| cdb_send | output | 1 | Push the CDB |
| data_in_go | output | 1 | Move one block from the device |
| data_out_go | output | 1 | Move one block to the device |
| dma_go | output | 1 | Start the DMA engine |
| dma_halt | output | 1 | Stop the DMA engine |
| cmd_done | output | 1 | Command finished |
| cmd_err | output | 1 | Finished with device error |
| resid_clear | output | 1 | Residual count becomes zero |
| warn_bogus_drq | output | 1 | First idle event inside a data phase |
| warn_bad_reason | output | 1 | First completion seen through reason code 0 |
| warn_dir | output | 1 | Data phase against command direction |
| warn_unknown | output | 1 | Event not expected in this phase |
| phase | output | 3 | Current phase |

## Verification
The assertions watch, on every cycle, the properties that hold regardless of stimulus:
- the exclusivity of the action strobes;
- acceptance of a start only from idle;
- the frozen phase under BSY;
- `dma_go` landing in the DMA phase;
- `dma_halt` always being followed by `cmd_done`;
- `resid_clear` only after a halt;
- each once-only warning firing at most once between resets.

The full contents of the state-by-event table need the bench's sweep. That sweep covers every reachable phase against every event code, across read, write and DMA commands. It also checks the direction mismatch, the DF/ERR and transport-fault mix at completion, and the re-arming of the warnings after reset.

// File: rtl/apc_pkg.sv
package apc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_CDB  = 3'd2,
    ST_DIN  = 3'd3,
    ST_DOUT = 3'd4,
    ST_DMA  = 3'd5
  } phase_t;

  typedef enum logic [2:0] {
    AC_NONE  = 3'd0,
    AC_CDB   = 3'd1,
    AC_IN    = 3'd2,
    AC_OUT   = 3'd3,
    AC_IDLEW = 3'd4,
    AC_DONE  = 3'd5,
    AC_DONEX = 3'd6,
    AC_UNK   = 3'd7
  } act_t;

  localparam int EV_W = 3;

  // phase event codes, {IO, CoD, DRQ}
  localparam logic [EV_W-1:0] EV_NOREASON = 3'd0;
  localparam logic [EV_W-1:0] EV_TO_DEV   = 3'd1;
  localparam logic [EV_W-1:0] EV_QUIET    = 3'd2;
  localparam logic [EV_W-1:0] EV_PACKET   = 3'd3;
  localparam logic [EV_W-1:0] EV_QUIET_IO = 3'd4;
  localparam logic [EV_W-1:0] EV_FROM_DEV = 3'd5;
  localparam logic [EV_W-1:0] EV_STATUS   = 3'd6;
  localparam logic [EV_W-1:0] EV_RESERVED = 3'd7;

  typedef struct packed {
    act_t   act;
    phase_t nxt;
  } lookup_t;

  function automatic logic [EV_W-1:0] make_event(input logic io, input logic cod,
                                                 input logic drq);
    return {io, cod, drq};
  endfunction

  function automatic logic status_fault(input logic df, input logic err);
    return df | err;
  endfunction

  function automatic lookup_t mk(input act_t a, input phase_t n);
    lookup_t r;
    r.act = a;
    r.nxt = n;
    return r;
  endfunction

  function automatic lookup_t phase_lookup(input phase_t s, input logic [EV_W-1:0] ev);
    lookup_t r;
    r = mk(AC_NONE, s);
    unique case (s)
      ST_CMD: begin
        if (ev == EV_PACKET)      r = mk(AC_CDB, ST_CDB);
        else if (ev == EV_STATUS) r = mk(AC_DONE, ST_IDLE);
        else                      r = mk(AC_UNK, ST_CMD);
      end
      ST_CDB: begin
        unique case (ev)
          EV_NOREASON: r = mk(AC_DONEX, ST_IDLE);
          EV_TO_DEV:   r = mk(AC_OUT, ST_DOUT);
          EV_FROM_DEV: r = mk(AC_IN, ST_DIN);
          EV_STATUS:   r = mk(AC_DONE, ST_IDLE);
          EV_RESERVED: r = mk(AC_UNK, ST_CDB);
          default:     r = mk(AC_NONE, ST_CDB);
        endcase
      end
      ST_DIN: begin
        unique case (ev)
          EV_NOREASON:           r = mk(AC_DONEX, ST_IDLE);
          EV_FROM_DEV:           r = mk(AC_IN, ST_DIN);
          EV_QUIET, EV_QUIET_IO: r = mk(AC_IDLEW, ST_DIN);
          EV_STATUS:             r = mk(AC_DONE, ST_IDLE);
          default:               r = mk(AC_UNK, ST_DIN);
        endcase
      end
      ST_DOUT: begin
        unique case (ev)
          EV_NOREASON:           r = mk(AC_DONEX, ST_IDLE);
          EV_TO_DEV:             r = mk(AC_OUT, ST_DOUT);
          EV_QUIET, EV_QUIET_IO: r = mk(AC_IDLEW, ST_DOUT);
          EV_STATUS:             r = mk(AC_DONE, ST_IDLE);
          default:               r = mk(AC_UNK, ST_DOUT);
        endcase
      end
      ST_DMA: begin
        if (ev == EV_NOREASON)    r = mk(AC_DONEX, ST_IDLE);
        else if (ev == EV_STATUS) r = mk(AC_DONE, ST_IDLE);
        else                      r = mk(AC_UNK, ST_DMA);
      end
      default: r = mk(AC_NONE, ST_IDLE);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/apc_event_decode.sv
module apc_event_decode
  import apc_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int REAS_W  = 8,
  parameter int BSY_BIT = 7,
  parameter int DF_BIT  = 5,
  parameter int DRQ_BIT = 3,
  parameter int ERR_BIT = 0,
  parameter int COD_BIT = 0,
  parameter int IO_BIT  = 1
) (
  input  logic [STAT_W-1:0] dev_status,
  input  logic [REAS_W-1:0] irq_reason,
  output logic [EV_W-1:0]   ev_code,
  output logic              ev_busy,
  output logic              ev_fault
);

  logic unused_bits;

  assign ev_code  = make_event(irq_reason[IO_BIT], irq_reason[COD_BIT], dev_status[DRQ_BIT]);
  assign ev_busy  = dev_status[BSY_BIT];
  assign ev_fault = status_fault(dev_status[DF_BIT], dev_status[ERR_BIT]);

  assign unused_bits = ^{dev_status, irq_reason};

endmodule

// File: rtl/apc_phase_table.sv
module apc_phase_table
  import apc_pkg::*;
(
  input  phase_t          cur,
  input  logic [EV_W-1:0] ev,
  output act_t            act,
  output phase_t          nxt
);

  lookup_t hit;

  always_comb begin
    hit = phase_lookup(cur, ev);
    act = hit.act;
    nxt = hit.nxt;
  end

endmodule

// File: rtl/apc_once_flags.sv
module apc_once_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  output logic [N-1:0] first
);

  logic [N-1:0] seen;

  for (genvar g = 0; g < N; g++) begin : g_flag
    assign first[g] = hit[g] & ~seen[g];
    always_ff @(posedge clk) begin
      if (rst)         seen[g] <= 1'b0;
      else if (hit[g]) seen[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/apc_sequencer.sv
module apc_sequencer
  import apc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_req,
  input  logic   start_rd,
  input  logic   start_wr,
  input  logic   start_dma,
  input  logic   irq_valid,
  input  logic   ev_busy,
  input  logic   ev_fault,
  input  logic   xfer_fault,
  input  act_t   lk_act,
  input  phase_t lk_nxt,
  input  logic   first_idle,
  input  logic   first_rex,
  output logic   hit_idle,
  output logic   hit_rex,
  output phase_t phase_q,
  output logic   pend_q,
  output logic   start_ack,
  output logic   start_busy,
  output logic   cdb_send,
  output logic   data_in_go,
  output logic   data_out_go,
  output logic   dma_go,
  output logic   dma_halt,
  output logic   cmd_done,
  output logic   cmd_err,
  output logic   resid_clear,
  output logic   warn_bogus_drq,
  output logic   warn_bad_reason,
  output logic   warn_dir,
  output logic   warn_unknown
);

  logic cmd_rd, cmd_wr, cmd_dma;
  logic pend_err, pend_rz;
  logic irq_take;
  logic can_start;

  assign can_start = (phase_q == ST_IDLE) && !pend_q;
  assign irq_take  = irq_valid && !ev_busy && (phase_q != ST_IDLE) && !pend_q;
  assign hit_idle  = irq_take && (lk_act == AC_IDLEW);
  assign hit_rex   = irq_take && (lk_act == AC_DONEX);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q         <= ST_IDLE;
      pend_q          <= 1'b0;
      pend_err        <= 1'b0;
      pend_rz         <= 1'b0;
      cmd_rd          <= 1'b0;
      cmd_wr          <= 1'b0;
      cmd_dma         <= 1'b0;
      start_ack       <= 1'b0;
      start_busy      <= 1'b0;
      cdb_send        <= 1'b0;
      data_in_go      <= 1'b0;
      data_out_go     <= 1'b0;
      dma_go          <= 1'b0;
      dma_halt        <= 1'b0;
      cmd_done        <= 1'b0;
      cmd_err         <= 1'b0;
      resid_clear     <= 1'b0;
      warn_bogus_drq  <= 1'b0;
      warn_bad_reason <= 1'b0;
      warn_dir        <= 1'b0;
      warn_unknown    <= 1'b0;
    end else begin
      start_ack       <= 1'b0;
      start_busy      <= 1'b0;
      cdb_send        <= 1'b0;
      data_in_go      <= 1'b0;
      data_out_go     <= 1'b0;
      dma_go          <= 1'b0;
      dma_halt        <= 1'b0;
      cmd_done        <= 1'b0;
      cmd_err         <= 1'b0;
      resid_clear     <= 1'b0;
      warn_bogus_drq  <= first_idle;
      warn_bad_reason <= first_rex;
      warn_dir        <= 1'b0;
      warn_unknown    <= 1'b0;

      // second half of a DMA completion: halt went out last cycle
      if (pend_q) begin
        pend_q      <= 1'b0;
        cmd_done    <= 1'b1;
        cmd_err     <= pend_err;
        resid_clear <= pend_rz;
      end

      if (start_req) begin
        if (can_start) begin
          phase_q   <= ST_CMD;
          start_ack <= 1'b1;
          cmd_rd    <= start_rd;
          cmd_wr    <= start_wr;
          cmd_dma   <= start_dma;
        end else begin
          start_busy <= 1'b1;
        end
      end

      if (irq_take) begin
        phase_q <= lk_nxt;
        unique case (lk_act)
          AC_CDB: begin
            cdb_send <= 1'b1;
            if (cmd_dma) begin
              dma_go  <= 1'b1;
              phase_q <= ST_DMA;
            end
          end
          AC_IN: begin
            if (cmd_rd) data_in_go <= 1'b1;
            else        warn_dir   <= 1'b1;
          end
          AC_OUT: begin
            if (cmd_wr) data_out_go <= 1'b1;
            else        warn_dir    <= 1'b1;
          end
          AC_DONE, AC_DONEX: begin
            if (phase_q == ST_DMA) begin
              dma_halt <= 1'b1;
              pend_q   <= 1'b1;
              pend_err <= ev_fault;
              pend_rz  <= !xfer_fault;
            end else begin
              cmd_done <= 1'b1;
              cmd_err  <= ev_fault;
            end
          end
          AC_UNK:  warn_unknown <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/atapi_phase_ctrl.sv
module atapi_phase_ctrl
  import apc_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int REAS_W  = 8,
  parameter int BSY_BIT = 7,
  parameter int DF_BIT  = 5,
  parameter int DRQ_BIT = 3,
  parameter int ERR_BIT = 0,
  parameter int COD_BIT = 0,
  parameter int IO_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic              start_dma,
  output logic              start_ack,
  output logic              start_busy,
  input  logic              irq_valid,
  input  logic [STAT_W-1:0] dev_status,
  input  logic [REAS_W-1:0] irq_reason,
  input  logic              xfer_fault,
  output logic              cdb_send,
  output logic              data_in_go,
  output logic              data_out_go,
  output logic              dma_go,
  output logic              dma_halt,
  output logic              cmd_done,
  output logic              cmd_err,
  output logic              resid_clear,
  output logic              warn_bogus_drq,
  output logic              warn_bad_reason,
  output logic              warn_dir,
  output logic              warn_unknown,
  output logic [2:0]        phase
);

  localparam int N_ONCE = 2;

  logic [EV_W-1:0]   ev_code;
  logic              ev_busy;
  logic              ev_fault;
  act_t              lk_act;
  phase_t            lk_nxt;
  phase_t            phase_q;
  logic              pend_q;
  logic              hit_idle, hit_rex;
  logic [N_ONCE-1:0] once_first;

  apc_event_decode #(
    .STAT_W(STAT_W), .REAS_W(REAS_W), .BSY_BIT(BSY_BIT), .DF_BIT(DF_BIT),
    .DRQ_BIT(DRQ_BIT), .ERR_BIT(ERR_BIT), .COD_BIT(COD_BIT), .IO_BIT(IO_BIT)
  ) u_dec (
    .dev_status(dev_status),
    .irq_reason(irq_reason),
    .ev_code   (ev_code),
    .ev_busy   (ev_busy),
    .ev_fault  (ev_fault)
  );

  apc_phase_table u_tbl (
    .cur(phase_q),
    .ev (ev_code),
    .act(lk_act),
    .nxt(lk_nxt)
  );

  apc_once_flags #(.N(N_ONCE)) u_once (
    .clk  (clk),
    .rst  (rst),
    .hit  ({hit_rex, hit_idle}),
    .first(once_first)
  );

  apc_sequencer u_seq (
    .clk            (clk),
    .rst            (rst),
    .start_req      (start_req),
    .start_rd       (start_rd),
    .start_wr       (start_wr),
    .start_dma      (start_dma),
    .irq_valid      (irq_valid),
    .ev_busy        (ev_busy),
    .ev_fault       (ev_fault),
    .xfer_fault     (xfer_fault),
    .lk_act         (lk_act),
    .lk_nxt         (lk_nxt),
    .first_idle     (once_first[0]),
    .first_rex      (once_first[1]),
    .hit_idle       (hit_idle),
    .hit_rex        (hit_rex),
    .phase_q        (phase_q),
    .pend_q         (pend_q),
    .start_ack      (start_ack),
    .start_busy     (start_busy),
    .cdb_send       (cdb_send),
    .data_in_go     (data_in_go),
    .data_out_go    (data_out_go),
    .dma_go         (dma_go),
    .dma_halt       (dma_halt),
    .cmd_done       (cmd_done),
    .cmd_err        (cmd_err),
    .resid_clear    (resid_clear),
    .warn_bogus_drq (warn_bogus_drq),
    .warn_bad_reason(warn_bad_reason),
    .warn_dir       (warn_dir),
    .warn_unknown   (warn_unknown)
  );

  assign phase = phase_q;

endmodule

// File: rtl/apc_checker.sv
module apc_checker (
  input logic       clk,
  input logic       rst,
  input logic       start_req,
  input logic       start_ack,
  input logic       start_busy,
  input logic       irq_valid,
  input logic       ev_busy,
  input logic       cdb_send,
  input logic       data_in_go,
  input logic       data_out_go,
  input logic       dma_go,
  input logic       dma_halt,
  input logic       cmd_done,
  input logic       resid_clear,
  input logic       warn_bogus_drq,
  input logic       warn_bad_reason,
  input logic       warn_unknown,
  input logic [2:0] phase
);

  logic [1:0] n_drq_warn;
  logic [1:0] n_reason_warn;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_drq_warn    <= 2'd0;
      n_reason_warn <= 2'd0;
    end else begin
      if (warn_bogus_drq && n_drq_warn != 2'd3)     n_drq_warn    <= n_drq_warn + 2'd1;
      if (warn_bad_reason && n_reason_warn != 2'd3) n_reason_warn <= n_reason_warn + 2'd1;
    end
  end

  p_ack_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
    start_ack |-> ($past(phase) == 3'd0 && phase == 3'd1 && !start_busy));

  p_frozen_on_bsy_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && ev_busy && phase != 3'd0 && !start_req) |=>
      ($stable(phase) && !cdb_send && !data_in_go && !data_out_go && !dma_halt
       && !cmd_done && !warn_unknown));

  p_one_action_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cdb_send, data_in_go, data_out_go, warn_bogus_drq, warn_unknown, cmd_done}));

  p_dma_go_lands_r7: assert property (@(posedge clk) disable iff (rst)
    dma_go |-> (cdb_send && phase == 3'd5));

  p_halt_then_done_r8: assert property (@(posedge clk) disable iff (rst)
    dma_halt |=> (cmd_done && phase == 3'd0));

  p_resid_after_halt_r9: assert property (@(posedge clk) disable iff (rst)
    resid_clear |-> (cmd_done && $past(dma_halt)));

  p_reason_warn_once_r10: assert property (@(posedge clk) disable iff (rst)
    warn_bad_reason |-> (n_reason_warn == 2'd0));

  p_drq_warn_once_r11: assert property (@(posedge clk) disable iff (rst)
    warn_bogus_drq |-> (n_drq_warn == 2'd0));

  p_reset_idle_r13: assert property (@(posedge clk)
    rst |=> (phase == 3'd0 && !cmd_done && !cdb_send && !start_ack));

endmodule

bind atapi_phase_ctrl apc_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .start_req      (start_req),
  .start_ack      (start_ack),
  .start_busy     (start_busy),
  .irq_valid      (irq_valid),
  .ev_busy        (ev_busy),
  .cdb_send       (cdb_send),
  .data_in_go     (data_in_go),
  .data_out_go    (data_out_go),
  .dma_go         (dma_go),
  .dma_halt       (dma_halt),
  .cmd_done       (cmd_done),
  .resid_clear    (resid_clear),
  .warn_bogus_drq (warn_bogus_drq),
  .warn_bad_reason(warn_bad_reason),
  .warn_unknown   (warn_unknown),
  .phase          (phase)
);

// File: tb/sim_atapi_phase_ctrl.sv
module sim_atapi_phase_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 0, start_rd = 0, start_wr = 0, start_dma = 0;
  logic irq_valid = 0, xfer_fault = 0;
  logic [7:0] dev_status = 8'h00, irq_reason = 8'h00;
  logic start_ack, start_busy, cdb_send, data_in_go, data_out_go, dma_go, dma_halt;
  logic cmd_done, cmd_err, resid_clear, warn_bogus_drq, warn_bad_reason, warn_dir, warn_unknown;
  logic [2:0] phase;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench-side model of the controller
  int  ms = 0;
  bit  m_rd = 0, m_wr = 0, m_dma = 0;
  bit  seen_idle = 0, seen_rex = 0;

  always #2 clk = ~clk;

  atapi_phase_ctrl u0 (
    .clk(clk), .rst(rst),
    .start_req(start_req), .start_rd(start_rd), .start_wr(start_wr), .start_dma(start_dma),
    .start_ack(start_ack), .start_busy(start_busy),
    .irq_valid(irq_valid), .dev_status(dev_status), .irq_reason(irq_reason),
    .xfer_fault(xfer_fault),
    .cdb_send(cdb_send), .data_in_go(data_in_go), .data_out_go(data_out_go),
    .dma_go(dma_go), .dma_halt(dma_halt), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .resid_clear(resid_clear), .warn_bogus_drq(warn_bogus_drq),
    .warn_bad_reason(warn_bad_reason), .warn_dir(warn_dir), .warn_unknown(warn_unknown),
    .phase(phase)
  );

  // [11]cdb [10]in [9]out [8]dma_go [7]halt [6]done [5]err [4]resid
  // [3]drq_warn [2]reason_warn [1]dir_warn [0]unknown
  function automatic logic [11:0] obs_vec();
    return {cdb_send, data_in_go, data_out_go, dma_go, dma_halt, cmd_done, cmd_err,
            resid_clear, warn_bogus_drq, warn_bad_reason, warn_dir, warn_unknown};
  endfunction

  task automatic chk(input string req, input logic [11:0] exp, input int exp_ph);
    n_chk++;
    if (obs_vec() !== exp || phase !== exp_ph[2:0]) begin
      n_bad++;
      $display("FAIL %s: strobes=%b phase=%0d expected strobes=%b phase=%0d",
               req, obs_vec(), phase, exp, exp_ph);
    end
  endtask

  // action codes: 0 none 1 cdb 2 in 3 out 4 idle-warn 5 done 6 done-by-reason0 7 unknown
  task automatic rule(input int s, input int e, output int act, output int nx);
    act = 7;
    nx  = s;
    if (e == 6) begin act = 5; nx = 0; end
    else if (s == 1) begin
      if (e == 3) begin act = 1; nx = 2; end
    end else if (e == 0) begin act = 6; nx = 0; end
    else if (s == 2) begin
      if (e == 1) begin act = 3; nx = 4; end
      else if (e == 5) begin act = 2; nx = 3; end
      else if (e != 7) act = 0;
    end else if (s == 3 || s == 4) begin
      if (e == 2 || e == 4) act = 4;
      else if (s == 3 && e == 5) act = 2;
      else if (s == 4 && e == 1) act = 3;
    end
  endtask

  function automatic string tag_of(input int s);
    case (s)
      1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic do_irq(input logic [2:0] ev, input logic df, input logic er,
                        input logic bsy, input logic terr);
    logic [11:0] e1, e2;
    bit two;
    int act, nx, nph;
    string req;
    e1 = '0; e2 = '0; two = 0; nph = ms;
    req = bsy ? "R3" : tag_of(ms);
    @(negedge clk);
    irq_valid  = 1'b1;
    dev_status = {bsy, 1'b0, df, 1'b0, ev[0], 2'b00, er};
    irq_reason = {6'b0, ev[2], ev[1]};
    xfer_fault = terr;
    if (ms != 0 && !bsy) begin
      rule(ms, int'(ev), act, nx);
      nph = nx;
      case (act)
        1: begin e1[11] = 1; if (m_dma) begin e1[8] = 1; nph = 5; end end
        2: if (m_rd) e1[10] = 1; else begin e1[1] = 1; req = "R12"; end
        3: if (m_wr) e1[9] = 1;  else begin e1[1] = 1; req = "R12"; end
        4: begin req = "R11"; if (!seen_idle) begin e1[3] = 1; seen_idle = 1; end end
        5, 6: begin
          req = (act == 6) ? "R10" : "R8";
          if (act == 6 && !seen_rex) begin e1[2] = 1; seen_rex = 1; end
          if (ms == 5) begin
            e1[7] = 1; two = 1;
            e2[6] = 1; e2[5] = df | er; e2[4] = !terr;
          end else begin
            e1[6] = 1; e1[5] = df | er;
          end
        end
        7: e1[0] = 1;
        default: ;
      endcase
    end
    @(negedge clk);
    irq_valid = 1'b0; dev_status = 8'h00; irq_reason = 8'h00; xfer_fault = 1'b0;
    chk(req, e1, nph);
    ms = nph;
    if (two) begin
      @(negedge clk);
      chk("R8/R9", e2, 0);
    end
  endtask

  task automatic do_start(input bit rd, input bit wr, input bit dma);
    bit ok;
    ok = (ms == 0);
    @(negedge clk);
    start_req = 1'b1; start_rd = rd; start_wr = wr; start_dma = dma;
    @(negedge clk);
    start_req = 1'b0; start_rd = 1'b0; start_wr = 1'b0; start_dma = 1'b0;
    if (ok) begin ms = 1; m_rd = rd; m_wr = wr; m_dma = dma; end
    n_chk++;
    if (start_ack !== ok || start_busy !== !ok || phase !== ms[2:0]) begin
      n_bad++;
      $display("FAIL R2: ack=%b busy=%b phase=%0d expected ack=%b busy=%b phase=%0d",
               start_ack, start_busy, phase, ok, !ok, ms);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R13 reset state", 12'b0, 0);

    // interrupt while idle is ignored (R3)
    do_irq(3'd3, 1'b0, 1'b0, 1'b0, 1'b0);

    // BSY drops the interrupt (R3), busy start refused (R2)
    do_start(1, 0, 0);
    do_irq(3'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    do_start(0, 1, 0);
    do_irq(3'd6, 1'b0, 1'b0, 1'b0, 1'b0);

    // sweep: every reachable phase against every event (R1 encoding throughout)
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int tgt = 1; tgt <= 5; tgt++) begin
        bit rd, wr, dma;
        rd = cfg[0]; wr = !cfg[0]; dma = cfg[1];
        if (dma && tgt >= 2 && tgt <= 4) continue;
        if (!dma && tgt == 5) continue;
        if (tgt == 3 && !rd) continue;
        if (tgt == 4 && !wr) continue;
        for (int e = 0; e < 8; e++) begin
          logic [2:0] ev;
          ev = e[2:0];
          do_start(rd, wr, dma);
          if (tgt >= 2) do_irq(3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
          if (tgt == 3) do_irq(3'd5, 1'b0, 1'b0, 1'b0, 1'b0);
          if (tgt == 4) do_irq(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
          do_irq(ev, ev[0] ^ cfg[0], ev[1] & cfg[1], 1'b0, ev[2]);
          if (ms != 0) do_irq(3'd6, 1'b0, ev[0], 1'b0, ev[1]);
        end
      end
    end

    // reset re-arms the once-only warnings (R13, R11, R10)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ms = 0; seen_idle = 0; seen_rex = 0;
    chk("R13 after reset", 12'b0, 0);
    do_start(1, 0, 0);
    do_irq(3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    do_irq(3'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    do_irq(3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    do_irq(3'd4, 1'b0, 1'b0, 1'b0, 1'b0);
    do_irq(3'd0, 1'b1, 1'b0, 1'b0, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule